// File: doc/BRIEF.md
# SPI Bus Master with Memory-Direct Transfer

This block is an SPI bus master that moves its payload straight between a synchronous byte memory and the serial lines. No processor has to handle each byte. Before a transfer, software sets up the following:

- a transmit pointer and byte count;
- a receive pointer and byte count;
- the clock polarity, the clock phase and the bit order;
- a clock divider;
- a fill byte.

A one-cycle start strobe then launches the transfer. For each byte the block reads the next transmit byte from memory and shifts it out on MOSI while it shifts in MISO. It then writes the received byte to memory.

The two counts are independent:

- If the transmit count is shorter than the receive count, the fill byte is sent for the remaining bytes.
- If the receive count is shorter than the transmit count, the extra received bytes are dropped.

Progress is reported through one-cycle event pulses: started, transmit-done, receive-done and end. A stop strobe ends the transfer once the byte in flight has completed. Two amount outputs give the number of bytes actually moved in each direction. Slave selection is left to external general-purpose outputs, and the block drives no select line.

Top module: `spi_dma_master`

## Requirements
- R1: When idle, `sck_o` equals `cfg_cpol_i`. With `cfg_cpha_i`=0, MISO is sampled and MOSI is valid on the first SCK edge of each bit. With `cfg_cpha_i`=1, MOSI changes on the first edge and MISO is sampled on the second edge. Each byte has exactly 16 SCK edges.
- R2: Transmit byte i is read from address `tx_ptr_i`+i, for i from 0 to `tx_len_i`-1, and is sent in that order. The most significant bit goes first when `cfg_lsb_first_i`=0, and the least significant bit goes first when it is 1.
- R3: Received byte i is written to address `rx_ptr_i`+i, for i from 0 to `rx_len_i`-1. A write is a cycle with `mem_req_o`=1 and `mem_we_o`=1. Read data is taken on the cycle after a read request.
- R4: Byte positions at or beyond the transmit count send `cfg_fill_i`. Bytes received at or beyond the receive count are not written, so memory past the receive buffer is unchanged.
- R5: A start strobe while idle raises `busy_o` on the next cycle and pulses `started_o` once. A start strobe while busy is ignored.
- R6: `endtx_o` pulses once, when the last transmit byte is read. `endrx_o` pulses once, when the last receive byte is written. A count of zero, or a stop before the last byte, gives no such pulse.
- R7: The transfer ends once both counts are used up. `end_o` pulses for one cycle as `busy_o` falls. A stop strobe ends the transfer after the byte that is in flight, and a zero-length transfer ends without any SCK edge.
- R8: `tx_amount_o` and `rx_amount_o` read 0 after reset and after a start. They then hold the number of bytes read and written, and they keep those values after the end.
- R9: Each SCK half-period within a byte lasts `cfg_div_i`+1 system clock cycles.
- R10: The pointers and counts are captured at start, so changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cpol_i | input | 1 | Idle level of SCK |
| cfg_cpha_i | input | 1 | 0: sample on the first edge of a bit, 1: sample on the second edge |
| cfg_lsb_first_i | input | 1 | 1: least significant bit first |
| cfg_div_i | input | DIV_W | SCK half-period minus one, in system clock cycles |
| cfg_fill_i | input | 8 | Byte sent once the transmit buffer is used up |
| tx_ptr_i | input | AW | Transmit buffer start address |
| tx_len_i | input | CW | Transmit byte count |
| rx_ptr_i | input | AW | Receive buffer start address |
| rx_len_i | input | CW | Receive byte count |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| started_o | output | 1 | Transfer-started event pulse |
| endtx_o | output | 1 | Last-transmit-byte-read event pulse |
| endrx_o | output | 1 | Last-receive-byte-written event pulse |
| end_o | output | 1 | Transfer-ended event pulse |
| tx_amount_o | output | CW | Bytes read for transmission |
| rx_amount_o | output | CW | Bytes written from reception |

## Verification
A slave model in the bench follows SCK in every combination of polarity, phase and bit order. It sends its own byte stream and records MOSI, so a wrong sampling edge or a reversed bit order shows up as corrupted bytes in both directions.

The directed runs cover the following:

- equal transmit and receive counts, which checks plain address sequencing;
- a receive count longer than the transmit count, which exposes the fill path;
- a transmit count longer than the receive count, which catches writes past the buffer through sentinel bytes;
- zero counts, which exercise the immediate end;
- a stop in mid-transfer;
- a second start that reprograms the pointers while the block is busy.

Seeded random runs then mix all of these with random dividers, and the measured half-periods show any error in the divider count.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned EDGE_CNT = 2 * BYTE_W;
  localparam int unsigned EDGE_W   = $clog2(EDGE_CNT + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE
  } dma_state_e;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_data_o
);
  logic [BYTE_W-1:0] tx_sr_q, rx_sr_q;
  logic [EDGE_W-1:0] edge_q;
  logic              phase_q, active_q;
  logic              lead, do_edge, sample_now, shift_now;

  // even edge index = leading edge of a bit cell
  assign lead       = ~edge_q[0];
  assign do_edge    = active_q && tick_i && (edge_q < EDGE_W'(EDGE_CNT));
  assign done_o     = active_q && tick_i && (edge_q == EDGE_W'(EDGE_CNT));
  assign sample_now = do_edge && (cpha_i ? !lead : lead);
  assign shift_now  = do_edge && (cpha_i ? (lead && edge_q != '0)
                                         : (!lead && edge_q != EDGE_W'(EDGE_CNT - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q  <= '0;
      rx_sr_q  <= '0;
      edge_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (load_i) begin
      tx_sr_q  <= data_i;
      edge_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b1;
    end else begin
      if (do_edge) begin
        phase_q <= ~phase_q;
        edge_q  <= edge_q + EDGE_W'(1);
      end
      if (sample_now)
        rx_sr_q <= lsb_first_i ? {miso_i, rx_sr_q[BYTE_W-1:1]}
                               : {rx_sr_q[BYTE_W-2:0], miso_i};
      if (shift_now)
        tx_sr_q <= lsb_first_i ? (tx_sr_q >> 1) : (tx_sr_q << 1);
      if (done_o) active_q <= 1'b0;
    end
  end

  assign active_o  = active_q;
  assign sck_o     = phase_q ^ cpol_i;
  assign mosi_o    = lsb_first_i ? tx_sr_q[0] : tx_sr_q[BYTE_W-1];
  assign rx_data_o = rx_sr_q;
endmodule

// File: rtl/spi_dma_master.sv
module spi_dma_master
  import spi_dma_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_lsb_first_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [BYTE_W-1:0] cfg_fill_i,
  input  logic [AW-1:0]     tx_ptr_i,
  input  logic [CW-1:0]     tx_len_i,
  input  logic [AW-1:0]     rx_ptr_i,
  input  logic [CW-1:0]     rx_len_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              started_o,
  output logic              endtx_o,
  output logic              endrx_o,
  output logic              end_o,
  output logic [CW-1:0]     tx_amount_o,
  output logic [CW-1:0]     rx_amount_o
);
  dma_state_e        state_q;
  logic [AW-1:0]     tx_ptr_q, rx_ptr_q;
  logic [CW-1:0]     tx_len_q, rx_len_q, tx_idx_q, rx_idx_q;
  logic              stop_q;
  logic              started_q, endtx_q, endrx_q, end_q;
  logic              tx_rem, rx_rem, finish;
  logic              sh_load, sh_done, sh_active, tick;
  logic [BYTE_W-1:0] sh_data, sh_rx;

  assign tx_rem = tx_idx_q < tx_len_q;
  assign rx_rem = rx_idx_q < rx_len_q;
  assign finish = stop_q || (!tx_rem && !rx_rem);

  spi_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sh_active),
    .div_i  (cfg_div_i),
    .tick_o (tick)
  );

  spi_shift_unit u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sh_load),
    .data_i      (sh_data),
    .cpol_i      (cfg_cpol_i),
    .cpha_i      (cfg_cpha_i),
    .lsb_first_i (cfg_lsb_first_i),
    .tick_i      (tick),
    .miso_i      (miso_i),
    .active_o    (sh_active),
    .done_o      (sh_done),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .rx_data_o   (sh_rx)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    sh_load     = 1'b0;
    sh_data     = cfg_fill_i;
    unique case (state_q)
      ST_FETCH: begin
        if (!finish && tx_rem) begin
          mem_req_o  = 1'b1;
          mem_addr_o = tx_ptr_q + AW'(tx_idx_q);
        end else if (!finish) begin
          sh_load = 1'b1;
        end
      end
      ST_LOAD: begin
        sh_load = 1'b1;
        sh_data = mem_rdata_i;
      end
      ST_STORE: begin
        if (rx_rem) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = rx_ptr_q + AW'(rx_idx_q);
          mem_wdata_o = sh_rx;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_ptr_q  <= '0;
      rx_ptr_q  <= '0;
      tx_len_q  <= '0;
      rx_len_q  <= '0;
      tx_idx_q  <= '0;
      rx_idx_q  <= '0;
      stop_q    <= 1'b0;
      started_q <= 1'b0;
      endtx_q   <= 1'b0;
      endrx_q   <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      started_q <= 1'b0;
      endtx_q   <= 1'b0;
      endrx_q   <= 1'b0;
      end_q     <= 1'b0;
      if (state_q != ST_IDLE && stop_i) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            tx_ptr_q  <= tx_ptr_i;
            rx_ptr_q  <= rx_ptr_i;
            tx_len_q  <= tx_len_i;
            rx_len_q  <= rx_len_i;
            tx_idx_q  <= '0;
            rx_idx_q  <= '0;
            stop_q    <= 1'b0;
            started_q <= 1'b1;
            state_q   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (finish) begin
            end_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tx_rem) begin
            state_q <= ST_LOAD;
          end else begin
            state_q <= ST_SHIFT;
          end
        end
        ST_LOAD: begin
          tx_idx_q <= tx_idx_q + CW'(1);
          if (tx_idx_q + CW'(1) == tx_len_q) endtx_q <= 1'b1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sh_done) state_q <= ST_STORE;
        end
        ST_STORE: begin
          if (rx_rem) begin
            rx_idx_q <= rx_idx_q + CW'(1);
            if (rx_idx_q + CW'(1) == rx_len_q) endrx_q <= 1'b1;
          end
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign started_o   = started_q;
  assign endtx_o     = endtx_q;
  assign endrx_o     = endrx_q;
  assign end_o       = end_q;
  assign tx_amount_o = tx_idx_q;
  assign rx_amount_o = rx_idx_q;
endmodule

// File: rtl/spi_dma_master_chk.sv
module spi_dma_master_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_cpol_i,
  input logic          sck_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          busy_o,
  input logic          started_o,
  input logic          endtx_o,
  input logic          endrx_o,
  input logic          end_o,
  input logic [CW-1:0] tx_amount_o,
  input logic [CW-1:0] rx_amount_o
);
  // R1
  sck_idle_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o == cfg_cpol_i);

  // R3
  store_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  // R5
  started_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_o |-> busy_o && !$past(busy_o));

  // R7
  end_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !busy_o && $past(busy_o));

  // R6
  endtx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    endtx_o |=> !endtx_o);

  // R6
  endrx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    endrx_o |=> !endrx_o);

  // R8
  amount_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (tx_amount_o >= $past(tx_amount_o)) && (rx_amount_o >= $past(rx_amount_o)));

  // R8
  amount_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(tx_amount_o) && $stable(rx_amount_o));
endmodule

bind spi_dma_master spi_dma_master_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_cpol_i  (cfg_cpol_i),
  .sck_o       (sck_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .busy_o      (busy_o),
  .started_o   (started_o),
  .endtx_o     (endtx_o),
  .endrx_o     (endrx_o),
  .end_o       (end_o),
  .tx_amount_o (tx_amount_o),
  .rx_amount_o (rx_amount_o)
);

// File: tb/spi_dma_master_bench.sv
module spi_dma_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpol = 0, cpha = 0, lsb = 0;
  logic [7:0]  div = 0, fill = 0;
  logic [15:0] tx_ptr = 0, rx_ptr = 0;
  logic [7:0]  tx_len = 0, rx_len = 0;
  logic        start = 0, stop = 0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        sck, mosi, miso;
  logic        busy, started, endtx, endrx, end_ev;
  logic [7:0]  tx_amt, rx_amt;

  always #5 clk = ~clk;

  spi_dma_master u_spi_dma_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_cpol_i(cpol), .cfg_cpha_i(cpha), .cfg_lsb_first_i(lsb),
    .cfg_div_i(div), .cfg_fill_i(fill),
    .tx_ptr_i(tx_ptr), .tx_len_i(tx_len), .rx_ptr_i(rx_ptr), .rx_len_i(rx_len),
    .start_i(start), .stop_i(stop),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .busy_o(busy), .started_o(started), .endtx_o(endtx), .endrx_o(endrx),
    .end_o(end_ev), .tx_amount_o(tx_amt), .rx_amount_o(rx_amt)
  );

  // memory model with a bench-side write port
  logic [7:0] mem [0:255];
  logic       bw_en = 0;
  logic [7:0] bw_addr = 0, bw_data = 0;
  always @(posedge clk) begin
    if (bw_en) mem[bw_addr] <= bw_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // slave model
  logic [7:0] sl_tx [0:31];
  logic [7:0] sl_rx [0:31];
  logic [7:0] exp_tx [0:31];
  logic       sl_clear = 1;
  int         ec, bi, hp_err, n_st, n_etx, n_erx, n_end;
  logic       prev_sck;
  logic [7:0] sh_in;
  longint     cyc = 0, last_edge = 0;

  function automatic logic bit_of(input logic [7:0] b, input int k, input logic l);
    return l ? b[k] : b[7-k];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (sl_clear) begin
      ec = 0; bi = 0; hp_err = 0; sh_in = 0; prev_sck = cpol;
      n_st = 0; n_etx = 0; n_erx = 0; n_end = 0;
      miso = cpha ? 1'b0 : bit_of(sl_tx[0], 0, lsb);
    end else begin
      if (started) n_st++;
      if (endtx)   n_etx++;
      if (endrx)   n_erx++;
      if (end_ev)  n_end++;
      if (sck !== prev_sck) begin
        logic lead;
        prev_sck = sck;
        lead = (ec % 2) == 0;
        if (ec != 0 && (cyc - last_edge) != longint'(div) + 1) hp_err++;
        last_edge = cyc;
        if (cpha ? !lead : lead) sh_in = lsb ? {mosi, sh_in[7:1]} : {sh_in[6:0], mosi};
        if (cpha && lead) miso = bit_of(sl_tx[bi % 32], ec / 2, lsb);
        if (!cpha && !lead && ec != 15) miso = bit_of(sl_tx[bi % 32], ec / 2 + 1, lsb);
        ec++;
        if (ec == 16) begin
          sl_rx[bi % 32] = sh_in;
          ec = 0;
          bi++;
          if (!cpha) miso = bit_of(sl_tx[bi % 32], 0, lsb);
        end
      end
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    bw_en = 1; bw_addr = a[7:0]; bw_data = d;
    @(negedge clk);
    bw_en = 0;
  endtask

  // mode 0 plain, 1 stop during byte 1, 2 start again while busy
  task automatic run_xfer(input logic p, input logic h, input logic l, input int dv,
                          input logic [7:0] fl, input int txp, input int txl,
                          input int rxp, input int rxl, input int mode);
    int n, etx, erx;
    bit got;
    cpol = p; cpha = h; lsb = l; div = dv[7:0]; fill = fl;
    tx_ptr = 16'(txp); tx_len = 8'(txl); rx_ptr = 16'(rxp); rx_len = 8'(rxl);
    for (int i = 0; i < 32; i++) begin
      exp_tx[i] = 8'($urandom);
      sl_tx[i]  = 8'($urandom);
    end
    for (int i = 0; i < txl; i++) poke(txp + i, exp_tx[i]);
    for (int i = 0; i <= rxl; i++) poke(rxp + i, 8'hEE);
    sl_clear = 1;
    @(negedge clk); @(negedge clk);
    sl_clear = 0;
    // R1 idle level follows polarity
    chk(sck == p, "R1 idle sck", sck, p);
    start = 1; @(negedge clk); start = 0;
    if (mode == 1) begin
      for (int t = 0; t < 20000; t++) begin
        if (bi == 1 && ec == 4) break;
        @(negedge clk);
      end
      stop = 1; @(negedge clk); stop = 0;
    end
    if (mode == 2) begin
      for (int t = 0; t < 20000; t++) begin
        if (bi == 0 && ec == 6) break;
        @(negedge clk);
      end
      // R10 R5 reprogram and restart mid-transfer
      tx_ptr = 16'(txp + 3); rx_ptr = 16'(rxp + 5); tx_len = 8'd1; rx_len = 8'd9;
      start = 1; @(negedge clk); start = 0;
    end
    got = 0;
    for (int t = 0; t < 20000; t++) begin
      if (n_end > 0) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R7 watchdog end", got, 1);
    @(negedge clk); @(negedge clk);
    n   = (mode == 1) ? 2 : ((txl > rxl) ? txl : rxl);
    etx = (n < txl) ? n : txl;
    erx = (n < rxl) ? n : rxl;
    chk(n_st == 1, "R5 started count", n_st, 1);
    chk(n_end == 1 && !busy, "R7 end once, idle", n_end, 1);
    chk(bi == n && ec == 0, "R7 byte count on bus", bi, n);
    chk(n_etx == ((etx == txl && txl > 0) ? 1 : 0), "R6 endtx", n_etx, (etx == txl && txl > 0));
    chk(n_erx == ((erx == rxl && rxl > 0) ? 1 : 0), "R6 endrx", n_erx, (erx == rxl && rxl > 0));
    chk(tx_amt == 8'(etx), "R8 tx amount", tx_amt, etx);
    chk(rx_amt == 8'(erx), "R8 rx amount", rx_amt, erx);
    chk(sck == p, "R1 sck idle after end", sck, p);
    chk(hp_err == 0, "R9 half period", hp_err, 0);
    for (int i = 0; i < n; i++) begin
      if (i < txl) chk(sl_rx[i] == exp_tx[i], "R2 R10 tx byte", sl_rx[i], exp_tx[i]);
      else         chk(sl_rx[i] == fl, "R4 fill byte", sl_rx[i], fl);
    end
    for (int i = 0; i < erx; i++)
      chk(mem[(rxp + i) % 256] == sl_tx[i], "R3 rx byte", mem[(rxp + i) % 256], sl_tx[i]);
    for (int i = erx; i <= rxl; i++)
      chk(mem[(rxp + i) % 256] == 8'hEE, "R4 untouched", mem[(rxp + i) % 256], 8'hEE);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !mem_req, "R7 reset idle", busy, 0);
    chk(tx_amt == 0 && rx_amt == 0, "R8 reset amounts", {tx_amt, rx_amt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sck == cpol, "R1 reset sck", sck, cpol);
    run_xfer(0, 0, 0, 1, 8'h5A, 0,  3, 128, 3, 0);
    run_xfer(1, 1, 1, 2, 8'hC3, 10, 2, 140, 5, 0);   // R4 fill
    run_xfer(0, 1, 0, 0, 8'h00, 20, 5, 150, 2, 0);   // R4 discard
    run_xfer(1, 0, 0, 1, 8'hFF, 0,  0, 160, 0, 0);   // R7 zero length
    run_xfer(0, 0, 1, 0, 8'h81, 0,  0, 170, 3, 0);   // R4 all fill
    run_xfer(1, 1, 0, 1, 8'h11, 30, 5, 180, 5, 1);   // R7 stop
    run_xfer(0, 1, 1, 2, 8'h22, 40, 4, 190, 4, 2);   // R10 R5 restart ignored
    run_xfer(1, 0, 1, 3, 8'h33, 50, 6, 200, 1, 0);   // R9 slow clock
    for (int k = 0; k < 10; k++)
      run_xfer(1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3),
               8'($urandom), $urandom_range(0, 60), $urandom_range(0, 7),
               128 + $urandom_range(0, 100), $urandom_range(0, 7), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule